// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates six interrupt sources on behalf of a small microcontroller core: USB, timer 0 overflow, timer 1 overflow, audio play, serial interface and audio record. A single-cycle pulse on a source's request line sets that source's request flag. The flag stays set until the source is serviced or software clears it. Each source has its own enable bit, and one global enable gates all of them.

Arbitration happens only on the rising edge of a periodic phase strobe. Any request that arrives between two strobe edges waits for the next one. On that edge the block picks the highest-priority source that is pending and enabled, provided the global enable is set and the core's stack is not full. It then emits a one-cycle acknowledge together with the vector address, clears the served flag and clears the global enable. Only the core's return-with-enable event sets the global enable again. A plain return leaves it as it is.

The source index gives the priority, with index 0 highest. The vector address is computed from the index, so the number of sources and the address spacing are parameters.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, every request flag is 0, the global enable is 0, the acknowledge is 0 and the vector output is 0x00.
- R2: A pulse on request line i sets flag i at the next clock edge. The flag stays set until it is served or cleared by software.
- R3: Arbitration happens only on a 0-to-1 transition of the phase strobe. A pending, enabled request is not served while the strobe stays low or stays high.
- R4: A source is served only when three conditions hold together: the global enable is 1, its own enable bit is 1, and the stack-full input is 0.
- R5: Priority is fixed by source index, with 0 highest: 0 USB, 1 timer 0, 2 timer 1, 3 play, 4 serial, 5 record.
- R6: The vector for source index i is 0x04 + 4*i. This gives 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18.
- R7: Acknowledge is a one-cycle pulse one clock after the strobe edge that wins arbitration. The vector is valid in that same cycle and reads 0x00 at all other times.
- R8: On acknowledge, the served flag and the global enable are both 0. Flags that were not chosen stay set.
- R9: A return-with-enable pulse sets the global enable. A plain return pulse leaves it unchanged.
- R10: A software clear mask clears the selected flags. A request pulse in the same cycle wins over the clear. A software write loads the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_stb | input | 1 | Phase strobe; its rising edge triggers arbitration |
| req_pulse | input | 6 | Per-source request pulses (index 0 = USB ... 5 = record) |
| src_en | input | 6 | Per-source enable bits |
| flag_clr | input | 6 | Software clear mask for the request flags |
| gie_wr | input | 1 | Software write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| ret_en | input | 1 | Return-with-enable event from the core |
| ret_plain | input | 1 | Plain return event from the core |
| stack_full | input | 1 | Core stack is full; inhibits acknowledge |
| irq_ack | output | 1 | One-cycle vectored-call request |
| irq_vector | output | 8 | Vector address, valid with irq_ack |
| req_flags | output | 6 | Current request flags |
| gie | output | 1 | Current global enable |

## Verification
Because the flags and the global enable are driven straight to the ports, a wrong internal state shows up one clock after the edge that caused it. A flag left stuck, or a global enable that fails to close on entry, would show as a second acknowledge on the next strobe edge. A broken priority chain or vector computation shows at the first acknowledge as the wrong vector. A strobe edge detector that fires on level would produce an acknowledge during a held strobe within a few cycles of re-enabling.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned DEF_NSRC     = 6;
   localparam int unsigned DEF_VEC_W    = 8;
   localparam int unsigned DEF_VEC_BASE = 4;
   localparam int unsigned DEF_VEC_STEP = 4;

   typedef enum logic [2:0] {
      SRC_USB    = 3'd0,
      SRC_TMR0   = 3'd1,
      SRC_TMR1   = 3'd2,
      SRC_PLAY   = 3'd3,
      SRC_SERIAL = 3'd4,
      SRC_RECORD = 3'd5
   } irq_src_e;

   function automatic int unsigned vec_addr(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned idx);
      return base + step * idx;
   endfunction
endpackage

// File: rtl/irq_strobe_sync.sv
module irq_strobe_sync #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   output logic sample_o
);
   generate
      if (EDGE_MODE) begin : g_edge
         logic stb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stb_q <= 1'b0;
            else        stb_q <= stb_i;
         end
         assign sample_o = stb_i & ~stb_q;

         // R3
         sample_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sample_o |=> !sample_o);
      end else begin : g_level
         assign sample_o = stb_i;
      end
   endgenerate
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] sw_clr_i,
   input  logic [N-1:0] ack_clr_i,
   output logic [N-1:0] flags_o
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          flags_o[i] <= 1'b0;
            else if (set_i[i])                   flags_o[i] <= 1'b1;
            else if (sw_clr_i[i] | ack_clr_i[i]) flags_o[i] <= 1'b0;
         end

         // R8
         served_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_clr_i[i] && !set_i[i]) |=> !flags_o[i]);
         // R10
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);
         // R2
         flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !sw_clr_i[i] && !ack_clr_i[i]) |=> flags_o[i]);
      end
   endgenerate
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int unsigned N  = 6,
   parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  grant_o,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign grant_o[i]  = req_i[i] & ~seen[i];
         assign seen[i+1]   = seen[i] | req_i[i];
      end
   endgenerate

   assign any_o = seen[N];

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IW'(i);
      end
   end

   // R5
   always_comb begin
      grant_onehot_chk: assert ($onehot0(grant_o));
   end
endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  logic ret_en_i,
   input  logic ret_plain_i,
   input  logic wr_i,
   input  logic wdata_i,
   output logic gie_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gie_o <= 1'b0;
      else if (take_i)   gie_o <= 1'b0;
      else if (ret_en_i) gie_o <= 1'b1;
      else if (wr_i)     gie_o <= wdata_i;
   end

   // R9
   reten_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en_i && !take_i) |=> gie_o);
   // R9
   plain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_plain_i && !ret_en_i && !wr_i && !take_i) |=> $stable(gie_o));
   // R8
   take_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> !gie_o);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
   parameter int unsigned NSRC      = irq_pkg::DEF_NSRC,
   parameter int unsigned VEC_W     = irq_pkg::DEF_VEC_W,
   parameter int unsigned VEC_BASE  = irq_pkg::DEF_VEC_BASE,
   parameter int unsigned VEC_STEP  = irq_pkg::DEF_VEC_STEP,
   parameter bit          EDGE_MODE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             phase_stb,
   input  logic [NSRC-1:0]  req_pulse,
   input  logic [NSRC-1:0]  src_en,
   input  logic [NSRC-1:0]  flag_clr,
   input  logic             gie_wr,
   input  logic             gie_wdata,
   input  logic             ret_en,
   input  logic             ret_plain,
   input  logic             stack_full,
   output logic             irq_ack,
   output logic [VEC_W-1:0] irq_vector,
   output logic [NSRC-1:0]  req_flags,
   output logic             gie
);
   localparam int unsigned IW      = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam int unsigned VEC_TOP = irq_pkg::vec_addr(VEC_BASE, VEC_STEP, NSRC - 1);

   generate
      if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
         $error("irq_vec_ctrl: NSRC out of range");
      end
      if (VEC_W < 1 || VEC_W > 31) begin : g_bad_vecw
         $error("irq_vec_ctrl: VEC_W out of range");
      end else if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
         $error("irq_vec_ctrl: highest vector does not fit VEC_W");
      end
      if (VEC_BASE == 0) begin : g_bad_base
         $error("irq_vec_ctrl: VEC_BASE must be nonzero so idle vector is distinct");
      end
   endgenerate

   logic            sample;
   logic [NSRC-1:0] eligible;
   logic [NSRC-1:0] grant;
   logic [NSRC-1:0] ack_clr;
   logic            take;
   logic [IW-1:0]   win_idx;
   logic            ack_q;
   logic [VEC_W-1:0] vec_q;
   logic [VEC_W-1:0] vec_next;

   irq_strobe_sync #(.EDGE_MODE(EDGE_MODE)) u_stb (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb_i    (phase_stb),
      .sample_o (sample)
   );

   assign eligible = req_flags & src_en & {NSRC{sample & gie & ~stack_full}};

   irq_prio_sel #(.N(NSRC), .IW(IW)) u_prio (
      .req_i   (eligible),
      .grant_o (grant),
      .any_o   (take),
      .idx_o   (win_idx)
   );

   assign ack_clr = take ? grant : '0;

   irq_flag_bank #(.N(NSRC)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (req_pulse),
      .sw_clr_i  (flag_clr),
      .ack_clr_i (ack_clr),
      .flags_o   (req_flags)
   );

   irq_gie_ctl u_gie (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_i      (take),
      .ret_en_i    (ret_en),
      .ret_plain_i (ret_plain),
      .wr_i        (gie_wr),
      .wdata_i     (gie_wdata),
      .gie_o       (gie)
   );

   assign vec_next = VEC_W'(irq_pkg::vec_addr(VEC_BASE, VEC_STEP, 32'(win_idx)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         vec_q <= '0;
      end else begin
         ack_q <= take;
         vec_q <= take ? vec_next : '0;
      end
   end

   assign irq_ack    = ack_q;
   assign irq_vector = vec_q;

   // R7
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack);
   // R7
   vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_ack |-> (irq_vector == '0));
   // R6
   vec_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (irq_vector != '0));
   // R8
   gie_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> !gie);
   // R4
   elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_ack) |-> ($past(gie) && !$past(stack_full)));
endmodule

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       phase_stb = 1'b0;
   logic [5:0] req_pulse = '0;
   logic [5:0] src_en = '0;
   logic [5:0] flag_clr = '0;
   logic       gie_wr = 1'b0;
   logic       gie_wdata = 1'b0;
   logic       ret_en = 1'b0;
   logic       ret_plain = 1'b0;
   logic       stack_full = 1'b0;
   logic       irq_ack;
   logic [7:0] irq_vector;
   logic [5:0] req_flags;
   logic       gie;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   irq_vec_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .phase_stb(phase_stb), .req_pulse(req_pulse),
      .src_en(src_en), .flag_clr(flag_clr), .gie_wr(gie_wr), .gie_wdata(gie_wdata),
      .ret_en(ret_en), .ret_plain(ret_plain), .stack_full(stack_full),
      .irq_ack(irq_ack), .irq_vector(irq_vector), .req_flags(req_flags), .gie(gie)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // all drives happen at negedge; checks at negedge after the relevant posedge
   task automatic cyc(); @(negedge clk); endtask

   task automatic pulse_req(input logic [5:0] m);
      req_pulse = m; cyc(); req_pulse = '0;
   endtask
   task automatic write_gie(input logic v);
      gie_wr = 1'b1; gie_wdata = v; cyc(); gie_wr = 1'b0;
   endtask
   task automatic clear_all();
      flag_clr = '1; cyc(); flag_clr = '0;
   endtask
   // raise strobe for one cycle; returns with ack cycle visible
   task automatic strobe();
      phase_stb = 1'b1; cyc(); phase_stb = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 flags", req_flags, 0);
      chk("R1 gie", gie, 0);
      chk("R1 ack", irq_ack, 0);
      chk("R1 vector", irq_vector, 0);
   endtask

   task automatic t_each_vector();
      src_en = '1;
      for (int i = 0; i < 6; i++) begin
         clear_all();
         write_gie(1'b1);
         pulse_req(6'(1 << i));
         chk("R2 flag latched", req_flags, 1 << i);
         strobe();
         chk("R7 ack", irq_ack, 1);
         chk("R6 vector", irq_vector, 4 + 4 * i);
         chk("R8 served flag", req_flags, 0);
         chk("R8 gie cleared", gie, 0);
         cyc();
         chk("R7 ack one cycle", irq_ack, 0);
         chk("R7 vector idle", irq_vector, 0);
      end
   endtask

   task automatic t_priority_returns();
      clear_all();
      src_en = '1;
      pulse_req(6'h3F);
      write_gie(1'b1);
      strobe();
      chk("R5 highest first", irq_vector, 8'h04);
      chk("R8 others latched", req_flags, 6'h3E);
      cyc();
      ret_plain = 1'b1; cyc(); ret_plain = 1'b0;
      chk("R9 plain return keeps gie", gie, 0);
      strobe();
      chk("R8 blocked while gie 0", irq_ack, 0);
      chk("R8 flags kept", req_flags, 6'h3E);
      ret_en = 1'b1; cyc(); ret_en = 1'b0;
      chk("R9 return-with-enable", gie, 1);
      strobe();
      chk("R5 timer0 next", irq_vector, 8'h08);
      chk("R8 flags after t0", req_flags, 6'h3C);
      cyc();
      src_en = 6'b111011;
      write_gie(1'b1);
      strobe();
      chk("R4 masked timer1 skipped", irq_vector, 8'h10);
      chk("R4 timer1 flag kept", req_flags, 6'h34);
      cyc();
   endtask

   task automatic t_gating();
      clear_all();
      src_en = '1;
      pulse_req(6'h20);
      write_gie(1'b1);
      stack_full = 1'b1;
      strobe();
      chk("R4 stack full blocks", irq_ack, 0);
      chk("R4 flag kept", req_flags, 6'h20);
      chk("R4 gie kept", gie, 1);
      stack_full = 1'b0;
      src_en = '0;
      strobe();
      chk("R4 source enable blocks", irq_ack, 0);
      src_en = '1;
      write_gie(1'b0);
      strobe();
      chk("R4 gie blocks", irq_ack, 0);
      write_gie(1'b1);
      chk("R10 gie write", gie, 1);
      for (int k = 0; k < 5; k++) begin
         cyc();
         chk("R3 no strobe no ack", irq_ack, 0);
      end
      // held strobe: only the rising edge arbitrates
      phase_stb = 1'b1; cyc();
      chk("R3 edge serves", irq_vector, 8'h18);
      pulse_req(6'h01);
      ret_en = 1'b1; cyc(); ret_en = 1'b0;
      for (int k = 0; k < 4; k++) begin
         cyc();
         chk("R3 held strobe no ack", irq_ack, 0);
      end
      chk("R3 usb still pending", req_flags, 6'h01);
      phase_stb = 1'b0; cyc();
      strobe();
      chk("R3 next edge serves", irq_vector, 8'h04);
      cyc();
   endtask

   task automatic t_software();
      pulse_req(6'h2A);
      chk("R2 several latched", req_flags, 6'h2A);
      flag_clr = 6'h0A; cyc(); flag_clr = '0;
      chk("R10 sw clear mask", req_flags, 6'h20);
      req_pulse = 6'h01; flag_clr = '1; cyc(); req_pulse = '0; flag_clr = '0;
      chk("R10 set wins over clear", req_flags, 6'h01);
      // new request on the served source at the acknowledge edge
      write_gie(1'b1);
      phase_stb = 1'b1; req_pulse = 6'h01; cyc(); phase_stb = 1'b0; req_pulse = '0;
      chk("R10 ack with new request", irq_ack, 1);
      chk("R10 flag re-set kept", req_flags, 6'h01);
      cyc();
   endtask

   initial begin
      repeat (3) cyc();
      t_reset();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_each_vector();
      t_priority_returns();
      t_gating();
      t_software();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule